// File: doc/BRIEF.md
# Boosted Cascade Stage Evaluator

This block decides whether one candidate sub-window survives a single stage of a boosted detection cascade. The caller hands it the linear address of the sub-window's top-left corner in a precomputed integral image and pulses a start strobe. For each weak classifier of the stage, the block reads that classifier's parameter word from a small external parameter ROM. It then fetches the integral-image corners that the feature's shape needs, one read per cycle, and builds the signed feature value from rectangle sums. It scales the value by a power-of-two shift and compares it against the classifier's own threshold. The direction of that comparison is set by a per-feature parity bit. A classifier that votes positive adds its signed weight to the stage score.

Once every classifier has been evaluated, the score is compared against a stage threshold. The block then reports pass or reject for one cycle, together with the sub-window address. A caller chaining stages forwards only passing addresses to the next stage. The integral-image memory and the parameter ROM both sit outside the block, and each answers a read in the cycle after its address is presented.

Top module: `csc_stage_eval`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, `busy`, `done`, `pass` and `ii_rd` are all 0.
- R2: `start` is accepted only when `busy` is 0. A `start` raised while busy has no effect: the read sequence, the timing and the reported `res_addr` stay those of the sub-window already in progress. `res_addr` equals the accepted `win_addr` in the `done` cycle.
- R3: Each feature is read in one of three shapes, chosen by its type code. Code 0 is two cells side by side, using 6 reads on a 2-row by 3-column corner grid. Code 1 is three cells side by side, using 8 reads on a 2 by 4 grid. Code 2 is a 2 by 2 cell block, using 9 reads on a 3 by 3 grid. Corners are read row by row, left to right, one per cycle with `ii_rd` high. The corner at grid (row r, column c) is read at `win_addr + (y + r*h)*IMG_W + x + c*w`.
- R4: A rectangle sum is BR − TR − BL + TL of its four corners. The feature value depends on the type code. For code 0 it is the right cell minus the left cell. For code 1 it is the two outer cells minus twice the middle cell. For code 2 it is top-left plus bottom-right minus top-right minus bottom-left.
- R5: The feature value is arithmetically shifted right by NORM_SHIFT (default 4) to give a scaled value. With parity 0, the classifier votes 1 when the scaled value is less than its threshold. With parity 1, it votes 1 when the scaled value is greater than its threshold. When the scaled value equals the threshold, the vote is 0.
- R6: The stage passes when the sum of the weights of the voting classifiers is strictly greater than the signed `stage_thr`. An equal sum rejects.
- R7: With N_f reads for feature f, `done` is high for exactly one cycle, Σ(N_f + 3) + 1 cycles after the edge that accepted `start`. `busy` is high in every cycle between those two points and low in the `done` cycle. `pass` is 0 whenever `done` is 0.
- R8: Parameter words are read in feature order. For each feature, `prm_addr` shows the feature index in the first cycle of that feature's slot. The word's fields, from bit 0 upward, are: type code (2 bits), parity (1 bit), x, y, w, h (CW bits each), threshold (TW bits, signed) and weight (WW bits, signed).
- R9: Weights are signed, so negative weights lower the score. The score register is wide enough that NUM_FEAT full-scale weights of either sign cannot overflow.
- R10: The integral-image port has a one-cycle read latency. The value returned in the cycle after each read is the value that enters the feature sum, and no read is issued while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin evaluating the sub-window at `win_addr` (taken only when idle) |
| win_addr | input | AW | Linear integral-image address of the sub-window's top-left corner |
| stage_thr | input | SCORE_W | Signed stage threshold |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | Sub-window passes this stage (valid with `done`) |
| res_addr | output | AW | Address of the evaluated sub-window |
| prm_addr | output | FIW | Parameter ROM read address (feature index) |
| prm_data | input | PW | Parameter word, one cycle after `prm_addr` |
| ii_rd | output | 1 | Integral-image read strobe |
| ii_addr | output | AW | Integral-image read address |
| ii_data | input | DW | Integral-image value, one cycle after the read |

## Verification
Each feature occupies a slot of N + 3 cycles, counted from the edge that accepts `start`. The parameter ROM address is due in the first cycle of the slot, and the corner reads are due in its third through (N+2)th cycles. The result strobe is due one cycle after the last slot, so with the default four eight-read features it arrives 45 cycles after acceptance. The bench builds a per-cycle schedule of these expectations before each run. It then compares strobes, addresses and the decision against that schedule at every falling edge, so an early, late or missing event shows up in the exact cycle it occurs. Thresholds are placed exactly on, and one step either side of, each computed feature value and stage score.

// File: rtl/csc_pkg.sv
// Shared types and shape tables for the cascade stage evaluator.
// Assumes feature shape codes 0..2; code 3 falls back to the code-0 shape.
package csc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOADP,
        ST_CAPT,
        ST_RD,
        ST_EVAL
    } csc_state_t;

    // Number of corner reads a feature shape needs.
    function automatic logic [3:0] corner_count(input logic [1:0] kind);
        case (kind)
            2'd1:    return 4'd8;
            2'd2:    return 4'd9;
            default: return 4'd6;
        endcase
    endfunction

    // Grid row of corner k (row-major order).
    function automatic logic [1:0] corner_row(input logic [1:0] kind, input logic [3:0] k);
        case (kind)
            2'd1:    return (k >= 4'd4) ? 2'd1 : 2'd0;
            2'd2:    return (k >= 4'd6) ? 2'd2 : ((k >= 4'd3) ? 2'd1 : 2'd0);
            default: return (k >= 4'd3) ? 2'd1 : 2'd0;
        endcase
    endfunction

    // Grid column of corner k (row-major order).
    function automatic logic [1:0] corner_col(input logic [1:0] kind, input logic [3:0] k);
        logic [3:0] c;
        case (kind)
            2'd1:    c = (k >= 4'd4) ? k - 4'd4 : k;
            2'd2:    c = (k >= 4'd6) ? k - 4'd6 : ((k >= 4'd3) ? k - 4'd3 : k);
            default: c = (k >= 4'd3) ? k - 4'd3 : k;
        endcase
        return c[1:0];
    endfunction

    // Net weight of corner k in the feature value, folding shared corners.
    function automatic logic signed [3:0] corner_coef(input logic [1:0] kind, input logic [3:0] k);
        case (kind)
            2'd1: begin
                case (k)
                    4'd0, 4'd7: return 4'sd1;
                    4'd1, 4'd6: return -4'sd3;
                    4'd2, 4'd5: return 4'sd3;
                    default:    return -4'sd1;
                endcase
            end
            2'd2: begin
                case (k)
                    4'd0, 4'd2, 4'd6, 4'd8: return 4'sd1;
                    4'd4:                   return 4'sd4;
                    default:                return -4'sd2;
                endcase
            end
            default: begin
                case (k)
                    4'd0, 4'd2: return -4'sd1;
                    4'd1:       return 4'sd2;
                    4'd4:       return -4'sd2;
                    default:    return 4'sd1;
                endcase
            end
        endcase
    endfunction

endpackage

// File: rtl/csc_corner_gen.sv
// Corner address generator: maps corner index k of a feature shape onto
// a linear integral-image address. Assumes a row stride of IMG_W words;
// the address wraps modulo 2**AW.
module csc_corner_gen
    import csc_pkg::*;
#(
    parameter int AW    = 17,
    parameter int CW    = 5,
    parameter int IMG_W = 320
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    kind,
    input  logic [3:0]    k,
    input  logic [CW-1:0] fx,
    input  logic [CW-1:0] fy,
    input  logic [CW-1:0] fw,
    input  logic [CW-1:0] fh,
    output logic [AW-1:0] addr
);
    localparam int OW = CW + 2;

    logic [1:0]    row, col;
    logic [OW-1:0] xoff, yoff;

    // Offset of the corner inside the sub-window, then linearised.
    always_comb begin
        row  = corner_row(kind, k);
        col  = corner_col(kind, k);
        yoff = OW'(fy) + OW'(row) * OW'(fh);
        xoff = OW'(fx) + OW'(col) * OW'(fw);
        addr = base + AW'(yoff) * AW'(IMG_W) + AW'(xoff);
    end
endmodule

// File: rtl/csc_weak_vote.sv
// Weak classifier datapath: accumulates coefficient-weighted corner values
// into the feature value, scales it by a right shift and produces the
// parity-directed vote. Assumes corner data arrives one per cycle with acc_en.
module csc_weak_vote
    import csc_pkg::*;
#(
    parameter int DW         = 20,
    parameter int TW         = 16,
    parameter int NORM_SHIFT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          acc_en,
    input  logic [1:0]    kind,
    input  logic [3:0]    kidx,
    input  logic [DW-1:0] ii_data,
    input  logic          parity,
    input  logic [TW-1:0] thr,
    output logic          vote
);
    localparam int FW = DW + 5;

    logic signed [FW-1:0] acc_q, feat_next, prod, scaled, thr_ext;
    logic signed [DW:0]   data_s;
    logic signed [3:0]    coef;

    // Feature value including the corner returned this cycle, and the vote on it.
    always_comb begin
        data_s    = $signed({1'b0, ii_data});
        coef      = corner_coef(kind, kidx);
        prod      = FW'(data_s) * FW'(coef);
        feat_next = acc_q + (acc_en ? prod : '0);
        scaled    = feat_next >>> NORM_SHIFT;
        thr_ext   = FW'($signed(thr));
        vote      = parity ? (scaled > thr_ext) : (scaled < thr_ext);
    end

    // Feature accumulator, cleared at the start of each feature.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) acc_q <= '0;
        else if (acc_en)     acc_q <= feat_next;
    end
endmodule

// File: rtl/csc_stage_eval.sv
// Boosted cascade stage evaluator (top). Sequences NUM_FEAT weak classifiers
// over one sub-window: parameter fetch, corner reads, vote, weighted score,
// then a one-cycle pass/reject strobe. Assumes both external memories answer
// one cycle after the address; starts are honoured only while idle.
module csc_stage_eval
    import csc_pkg::*;
#(
    parameter int AW         = 17,
    parameter int DW         = 20,
    parameter int IMG_W      = 320,
    parameter int CW         = 5,
    parameter int TW         = 16,
    parameter int WW         = 12,
    parameter int NUM_FEAT   = 4,
    parameter int SCORE_W    = 16,
    parameter int NORM_SHIFT = 4,
    localparam int FIW = (NUM_FEAT > 1) ? $clog2(NUM_FEAT) : 1,
    localparam int PW  = 3 + 4 * CW + TW + WW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [AW-1:0]      win_addr,
    input  logic [SCORE_W-1:0] stage_thr,
    output logic               busy,
    output logic               done,
    output logic               pass,
    output logic [AW-1:0]      res_addr,
    output logic [FIW-1:0]     prm_addr,
    input  logic [PW-1:0]      prm_data,
    output logic               ii_rd,
    output logic [AW-1:0]      ii_addr,
    input  logic [DW-1:0]      ii_data
);
    localparam int ACC_W = WW + $clog2(NUM_FEAT + 1);
    localparam int CMP_W = ((ACC_W > SCORE_W) ? ACC_W : SCORE_W) + 1;
    localparam int X_LO  = 3;
    localparam int Y_LO  = X_LO + CW;
    localparam int W_LO  = Y_LO + CW;
    localparam int H_LO  = W_LO + CW;
    localparam int T_LO  = H_LO + CW;
    localparam int WT_LO = T_LO + TW;

    csc_state_t             state_q;
    logic [AW-1:0]          base_q;
    logic [FIW-1:0]         feat_q;
    logic [1:0]             kind_q;
    logic                   par_q;
    logic [CW-1:0]          fx_q, fy_q, fw_q, fh_q;
    logic [TW-1:0]          thr_q;
    logic signed [WW-1:0]   wt_q;
    logic [3:0]             rd_k, kq;
    logic                   dvalid_q;
    logic signed [ACC_W-1:0] score_q, score_next;
    logic                   done_q, pass_q;
    logic                   vote;
    logic                   last_rd, last_feat;

    csc_corner_gen #(.AW(AW), .CW(CW), .IMG_W(IMG_W)) corner_i (
        .base (base_q),
        .kind (kind_q),
        .k    (rd_k),
        .fx   (fx_q),
        .fy   (fy_q),
        .fw   (fw_q),
        .fh   (fh_q),
        .addr (ii_addr)
    );

    csc_weak_vote #(.DW(DW), .TW(TW), .NORM_SHIFT(NORM_SHIFT)) vote_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q == ST_CAPT),
        .acc_en  (dvalid_q),
        .kind    (kind_q),
        .kidx    (kq),
        .ii_data (ii_data),
        .parity  (par_q),
        .thr     (thr_q),
        .vote    (vote)
    );

    // Output views and end-of-phase conditions.
    always_comb begin
        busy       = (state_q != ST_IDLE);
        ii_rd      = (state_q == ST_RD);
        prm_addr   = feat_q;
        res_addr   = base_q;
        done       = done_q;
        pass       = pass_q;
        last_rd    = (rd_k == corner_count(kind_q) - 4'd1);
        last_feat  = (feat_q == FIW'(NUM_FEAT - 1));
        score_next = score_q + (vote ? ACC_W'(wt_q) : '0);
    end

    // Read-return tracking: which corner index the incoming data belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvalid_q <= 1'b0;
            kq       <= '0;
        end else begin
            dvalid_q <= (state_q == ST_RD);
            kq       <= rd_k;
        end
    end

    // Stage sequencer: parameter fetch, corner reads, vote, final decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            feat_q  <= '0;
            kind_q  <= '0;
            par_q   <= 1'b0;
            fx_q    <= '0;
            fy_q    <= '0;
            fw_q    <= '0;
            fh_q    <= '0;
            thr_q   <= '0;
            wt_q    <= '0;
            rd_k    <= '0;
            score_q <= '0;
            done_q  <= 1'b0;
            pass_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        base_q  <= win_addr;
                        feat_q  <= '0;
                        score_q <= '0;
                        state_q <= ST_LOADP;
                    end
                end
                ST_LOADP: state_q <= ST_CAPT;
                ST_CAPT: begin
                    kind_q  <= prm_data[1:0];
                    par_q   <= prm_data[2];
                    fx_q    <= prm_data[X_LO +: CW];
                    fy_q    <= prm_data[Y_LO +: CW];
                    fw_q    <= prm_data[W_LO +: CW];
                    fh_q    <= prm_data[H_LO +: CW];
                    thr_q   <= prm_data[T_LO +: TW];
                    wt_q    <= $signed(prm_data[WT_LO +: WW]);
                    rd_k    <= '0;
                    state_q <= ST_RD;
                end
                ST_RD: begin
                    rd_k <= rd_k + 4'd1;
                    if (last_rd) state_q <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (last_feat) begin
                        done_q  <= 1'b1;
                        pass_q  <= (CMP_W'(score_next) > CMP_W'($signed(stage_thr)));
                        state_q <= ST_IDLE;
                    end else begin
                        score_q <= score_next;
                        feat_q  <= feat_q + FIW'(1);
                        state_q <= ST_LOADP;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/csc_stage_eval_chk.sv
// Protocol checker for csc_stage_eval, attached through bind.
// Assumes only the top-level ports; no internal state is observed.
module csc_stage_eval_chk #(
    parameter int AW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          pass,
    input logic          ii_rd,
    input logic [AW-1:0] res_addr
);
    // R7: the result strobe lasts exactly one cycle.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a result only follows a busy period.
    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R7: pass is never reported outside the result strobe.
    assert_pass_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    // R2: work only begins because of a start request.
    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R2: the sub-window address cannot change mid-evaluation.
    assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(res_addr));

    // R10: no integral-image read while idle.
    assert_no_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ii_rd |-> busy);
endmodule

bind csc_stage_eval csc_stage_eval_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .pass     (pass),
    .ii_rd    (ii_rd),
    .res_addr (res_addr)
);

// File: tb/csc_stage_eval_tb_top.sv
// Bench for csc_stage_eval: behavioural per-cycle schedule compared on every clock.
module csc_stage_eval_tb_top;
    localparam int AW = 17, DW = 20, CW = 5, TW = 16, WW = 12, NF = 4;
    localparam int PW = 3 + 4 * CW + TW + WW;
    localparam int IMGW = 320;

    logic clk = 1'b0;
    logic rst_n;
    logic start;
    logic [AW-1:0] win_addr;
    logic [15:0] stage_thr;
    logic busy, done, pass, ii_rd;
    logic [AW-1:0] res_addr, ii_addr;
    logic [1:0] prm_addr;
    logic [PW-1:0] prm_data;
    logic [DW-1:0] ii_data;

    int nchk = 0, nfail = 0;

    always #4 clk = ~clk;

    csc_stage_eval dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .win_addr(win_addr),
        .stage_thr(stage_thr), .busy(busy), .done(done), .pass(pass),
        .res_addr(res_addr), .prm_addr(prm_addr), .prm_data(prm_data),
        .ii_rd(ii_rd), .ii_addr(ii_addr), .ii_data(ii_data)
    );

    // Feature configuration (bench side).
    int f_kind[NF], f_par[NF], f_x[NF], f_y[NF], f_w[NF], f_h[NF], f_thr[NF], f_wt[NF];
    logic [PW-1:0] rom[NF];

    // Integral image is a deterministic function of address (no storage).
    function automatic int iiv(input int a);
        int m = a & 32'h1FFFF;
        return (m * 1103 + (m >> 3) * 71 + 17) & 32'hFFF;
    endfunction

    always @(posedge clk) begin
        prm_data <= rom[prm_addr];
        ii_data  <= DW'(iiv(int'(ii_addr)));
    end

    function automatic int at(input int base, input int xx, input int yy);
        return (base + yy * IMGW + xx) & 32'h1FFFF;
    endfunction

    function automatic int rsum(input int base, input int xx, input int yy, input int w, input int h);
        return iiv(at(base, xx + w, yy + h)) - iiv(at(base, xx + w, yy))
             - iiv(at(base, xx, yy + h)) + iiv(at(base, xx, yy));
    endfunction

    function automatic int feat(input int base, input int f);
        int x = f_x[f], y = f_y[f], w = f_w[f], h = f_h[f];
        if (f_kind[f] == 0)
            return rsum(base, x + w, y, w, h) - rsum(base, x, y, w, h);
        else if (f_kind[f] == 1)
            return rsum(base, x, y, w, h) + rsum(base, x + 2 * w, y, w, h) - 2 * rsum(base, x + w, y, w, h);
        else
            return rsum(base, x, y, w, h) + rsum(base, x + w, y + h, w, h)
                 - rsum(base, x + w, y, w, h) - rsum(base, x, y + h, w, h);
    endfunction

    function automatic int scaled(input int base, input int f);
        return feat(base, f) >>> 4;
    endfunction

    function automatic int nreads(input int f);
        return (f_kind[f] == 0) ? 6 : ((f_kind[f] == 1) ? 8 : 9);
    endfunction

    task automatic set_feat(input int f, input int kind, input int par, input int x, input int y,
                            input int w, input int h, input int thr, input int wt);
        f_kind[f] = kind; f_par[f] = par; f_x[f] = x; f_y[f] = y;
        f_w[f] = w; f_h[f] = h; f_thr[f] = thr; f_wt[f] = wt;
        rom[f] = {WW'(wt), TW'(thr), CW'(h), CW'(w), CW'(y), CW'(x), 1'(par), 2'(kind)};
    endtask

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int model_score(input int base);
        int s = 0;
        for (int f = 0; f < NF; f++) begin
            int v = scaled(base, f);
            bit vt = f_par[f] ? (v > f_thr[f]) : (v < f_thr[f]);
            if (vt) s += f_wt[f];
        end
        return s;
    endfunction

    // One evaluation with a per-cycle expected schedule.
    task automatic run_case(input int base, input int sthr, input bit extra, input string req);
        bit e_rd[64];
        int e_addr[64], e_prm[64];
        int o = 1, score, len;
        bit e_pass;
        for (int c = 0; c < 64; c++) begin e_rd[c] = 0; e_addr[c] = 0; e_prm[c] = -1; end
        for (int f = 0; f < NF; f++) begin
            int cols = (f_kind[f] == 1) ? 4 : 3;
            e_prm[o] = f;
            for (int k = 0; k < nreads(f); k++) begin
                e_rd[o + 2 + k] = 1'b1;
                e_addr[o + 2 + k] = at(base, f_x[f] + (k % cols) * f_w[f], f_y[f] + (k / cols) * f_h[f]);
            end
            o += nreads(f) + 3;
        end
        len = o;
        score = model_score(base);
        e_pass = (score > sthr);
        stage_thr = 16'(sthr);
        win_addr = AW'(base);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= len; c++) begin
            chk(busy == (c < len), "R7", "busy", busy, c < len);
            chk(done == (c == len), "R7", "done", done, c == len);
            if (c == len) begin
                chk(pass == e_pass, req, "pass", pass, e_pass);
                chk(res_addr == AW'(base), "R2", "res_addr", res_addr, base);
            end else begin
                chk(pass == 1'b0, "R7", "pass outside done", pass, 0);
            end
            chk(ii_rd == e_rd[c], "R3", "ii_rd", ii_rd, e_rd[c]);
            if (e_rd[c]) chk(int'(ii_addr) == e_addr[c], "R3 R10", "ii_addr", ii_addr, e_addr[c]);
            if (e_prm[c] >= 0) chk(int'(prm_addr) == e_prm[c], "R8", "prm_addr", prm_addr, e_prm[c]);
            if (extra && c == 4) begin start = 1'b1; win_addr = AW'(base + 777); end
            if (extra && c == 5) start = 1'b0;
            if (c < len) @(negedge clk);
        end
    endtask

    initial begin
        int s;
        rst_n = 1'b0; start = 1'b0; win_addr = '0; stage_thr = '0;
        for (int f = 0; f < NF; f++) rom[f] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pass && !ii_rd, "R1", "outputs in reset", {busy, done, pass, ii_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !pass && !ii_rd, "R1", "outputs after reset", {busy, done, pass, ii_rd}, 0);

        // Mixed shapes and parities.
        set_feat(0, 0, 0, 2, 3, 4, 5, 0, 300);
        set_feat(1, 1, 1, 1, 6, 3, 4, 10, -200);
        set_feat(2, 2, 0, 5, 2, 5, 6, -5, 450);
        set_feat(3, 0, 1, 8, 9, 6, 3, 3, 120);
        s = model_score(1000);
        run_case(1000, s - 1, 1'b0, "R4 R5 R6");
        run_case(1000, s, 1'b0, "R6");
        s = model_score(5321);
        run_case(5321, s - 1, 1'b0, "R4 R6");
        run_case(5321, s + 1, 1'b0, "R6");

        // Thresholds exactly on and one step past each scaled feature value.
        set_feat(0, 0, 0, 2, 3, 4, 5, scaled(2000, 0), 500);
        set_feat(1, 1, 1, 1, 6, 3, 4, scaled(2000, 1), 400);
        set_feat(2, 2, 0, 5, 2, 5, 6, scaled(2000, 2) + 1, 60);
        set_feat(3, 0, 1, 8, 9, 6, 3, scaled(2000, 3) - 1, 7);
        run_case(2000, 66, 1'b0, "R5 R6");
        run_case(2000, 67, 1'b0, "R5 R6");

        // Four-cell shapes with negative weights; a stray start mid-run.
        set_feat(0, 2, 0, 1, 1, 3, 3, 2047, -2048);
        set_feat(1, 2, 1, 4, 2, 4, 4, -2048, -2048);
        set_feat(2, 2, 0, 0, 0, 6, 5, 2047, -1000);
        set_feat(3, 1, 1, 2, 8, 4, 2, -2048, 2047);
        s = model_score(3300);
        run_case(3300, s - 1, 1'b1, "R9 R6");
        run_case(3300, s, 1'b1, "R9 R2");
        run_case(40000, model_score(40000) - 1, 1'b0, "R9 R4");

        @(negedge clk);
        chk(!busy && !done && !ii_rd, "R1", "idle after runs", {busy, done, ii_rd}, 0);
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule